// File: doc/BRIEF.md
# 72/64 Single-Error-Correct Double-Error-Detect Checker

This block protects a 64-bit word with 8 check bits. On the write side it derives the check bits from the data word combinationally, so they can be stored next to the data. On the read side it takes a stored 64-bit word and its 8 stored check bits with a valid strobe. It recomputes the check bits from the data and XORs them with the stored ones to form an 8-bit syndrome. From the syndrome it decides whether the word is clean, holds one flipped bit, or is uncorrectable.

The parity-check matrix is not a textbook Hamming layout. Each data bit carries a fixed 8-bit column code, and a flipped check bit k shows up as the one-hot pattern 1<<k. A single flipped data bit is corrected in the output word. For a single flipped check bit the output word is left unchanged and the position is reported. All read-side results appear one clock after the strobe, together with an output valid.

Top module: `ecc72_checker`

## Requirements
- R1: `wr_check[k]` is the XOR of every `wr_data` bit whose column code (listed in R5) has bit k set. The path is combinational.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `rd_valid` was sampled high, and low otherwise. All read-side outputs belong to that strobe.
- R3: `out_syndrome` equals the check bits recomputed from `rd_data` by the R1 rule, XOR `rd_check`.
- R4: A zero syndrome gives `out_ce`=0 and `out_ue`=0, with `out_data` equal to `rd_data`.
- R5: A syndrome equal to the column code of data bit i gives `out_ce`=1, `out_ue`=0, `out_bit`=i and `out_data` = `rd_data` with bit i inverted. The column codes for bits 0 to 63, in hex, are: f4 f1 ec ea e9 e6 e5 e3, dc da d9 d6 d5 d3 ce cb, b5 b0 ad ab a8 a7 a4 a2, 9d 9b 98 97 94 92 8f 8a, 75 70 6d 6b 68 67 64 62, 5e 5b 58 57 54 52 4f 4a, 34 31 2c 2a 29 26 25 23, 1c 1a 19 16 15 13 0e 0b.
- R6: A one-hot syndrome 1<<k gives `out_ce`=1, `out_ue`=0, `out_bit`=64+k, and `out_data` equal to `rd_data`.
- R7: Any other nonzero syndrome gives `out_ue`=1, `out_ce`=0, `out_bit`=0, and `out_data` equal to `rd_data`. This covers every double-bit error and the value 0x03.
- R8: While reset is asserted, every output register reads zero. After a cycle with `rd_valid` low, `out_data`, `out_syndrome`, `out_ce`, `out_ue` and `out_bit` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_data | input | 64 | Word to be stored |
| wr_check | output | 8 | Check bits for `wr_data` |
| rd_valid | input | 1 | Read word and check bits are valid this cycle |
| rd_data | input | 64 | Data word read from storage |
| rd_check | input | 8 | Check bits read from storage |
| out_valid | output | 1 | Read-side results valid |
| out_data | output | 64 | Corrected data word |
| out_syndrome | output | 8 | Syndrome of the read word |
| out_ce | output | 1 | Correctable single-bit error |
| out_ue | output | 1 | Uncorrectable error |
| out_bit | output | 7 | Error position: 0..63 data bit, 64..71 check bit |

## Verification
The write-side generator and the read-side decoder work in the same cycle on unrelated words. On every read strobe the bench also drives a fresh random word on the write port. It then checks `wr_check` against its own arithmetic encoding in that cycle, and checks the registered read result one cycle later. Errors are injected at each of the 72 positions on several data patterns, as random double-bit pairs, and as the 0x03 pattern. The bench works out each expected class by searching its own copy of the column table.

// File: rtl/ecc72_pkg.sv
`timescale 1ns/1ps
package ecc72_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int IDX_W  = $clog2(CODE_W);

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_CE   = 2'd1,
    ERR_UE   = 2'd2
  } err_kind_e;

  // Column code of each data bit in the parity-check matrix
  function automatic logic [CHK_W-1:0] col_code(input int unsigned idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0: c = 8'hf4;  1: c = 8'hf1;  2: c = 8'hec;  3: c = 8'hea;
      4: c = 8'he9;  5: c = 8'he6;  6: c = 8'he5;  7: c = 8'he3;
      8: c = 8'hdc;  9: c = 8'hda; 10: c = 8'hd9; 11: c = 8'hd6;
      12: c = 8'hd5; 13: c = 8'hd3; 14: c = 8'hce; 15: c = 8'hcb;
      16: c = 8'hb5; 17: c = 8'hb0; 18: c = 8'had; 19: c = 8'hab;
      20: c = 8'ha8; 21: c = 8'ha7; 22: c = 8'ha4; 23: c = 8'ha2;
      24: c = 8'h9d; 25: c = 8'h9b; 26: c = 8'h98; 27: c = 8'h97;
      28: c = 8'h94; 29: c = 8'h92; 30: c = 8'h8f; 31: c = 8'h8a;
      32: c = 8'h75; 33: c = 8'h70; 34: c = 8'h6d; 35: c = 8'h6b;
      36: c = 8'h68; 37: c = 8'h67; 38: c = 8'h64; 39: c = 8'h62;
      40: c = 8'h5e; 41: c = 8'h5b; 42: c = 8'h58; 43: c = 8'h57;
      44: c = 8'h54; 45: c = 8'h52; 46: c = 8'h4f; 47: c = 8'h4a;
      48: c = 8'h34; 49: c = 8'h31; 50: c = 8'h2c; 51: c = 8'h2a;
      52: c = 8'h29; 53: c = 8'h26; 54: c = 8'h25; 55: c = 8'h23;
      56: c = 8'h1c; 57: c = 8'h1a; 58: c = 8'h19; 59: c = 8'h16;
      60: c = 8'h15; 61: c = 8'h13; 62: c = 8'h0e; 63: c = 8'h0b;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Data bits that feed check bit k
  function automatic logic [DATA_W-1:0] row_mask(input int unsigned k);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = col_code(i);
      m[i] = c[k];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc72_encode.sv
`timescale 1ns/1ps
module ecc72_encode
  import ecc72_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  check
);
  for (genvar k = 0; k < CHK_W; k++) begin : g_row
    localparam logic [DATA_W-1:0] ROW = row_mask(k);
    assign check[k] = ^(data & ROW);
  end
endmodule

// File: rtl/ecc72_classify.sv
`timescale 1ns/1ps
module ecc72_classify
  import ecc72_pkg::*;
(
  input  logic [CHK_W-1:0]  syndrome,
  output err_kind_e         kind,
  output logic [DATA_W-1:0] flip_mask,
  output logic [IDX_W-1:0]  position
);
  logic [DATA_W-1:0] data_hit;
  logic [CHK_W-1:0]  chk_hit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_dcol
    localparam logic [CHK_W-1:0] COL = col_code(i);
    assign data_hit[i] = (syndrome == COL);
  end

  for (genvar k = 0; k < CHK_W; k++) begin : g_ccol
    localparam logic [CHK_W-1:0] ONEHOT = CHK_W'(1) << k;
    assign chk_hit[k] = (syndrome == ONEHOT);
  end

  assign flip_mask = data_hit;

  always_comb begin
    position = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (data_hit[i]) position = position | IDX_W'(i);
    end
    for (int k = 0; k < CHK_W; k++) begin
      if (chk_hit[k]) position = position | IDX_W'(DATA_W + k);
    end
  end

  always_comb begin
    if (syndrome == '0)             kind = ERR_NONE;
    else if (|data_hit || |chk_hit) kind = ERR_CE;
    else                            kind = ERR_UE;
  end
endmodule

// File: rtl/ecc72_checker.sv
`timescale 1ns/1ps
module ecc72_checker
  import ecc72_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] wr_data,
  output logic [7:0]  wr_check,
  input  logic        rd_valid,
  input  logic [63:0] rd_data,
  input  logic [7:0]  rd_check,
  output logic        out_valid,
  output logic [63:0] out_data,
  output logic [7:0]  out_syndrome,
  output logic        out_ce,
  output logic        out_ue,
  output logic [6:0]  out_bit
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write side
  ecc72_encode u_wr_enc (
    .data  (wr_data),
    .check (wr_check)
  );

  // read side
  logic [CHK_W-1:0]  rd_recalc;
  logic [CHK_W-1:0]  syn;
  err_kind_e         kind;
  logic [DATA_W-1:0] flip_mask;
  logic [IDX_W-1:0]  position;

  ecc72_encode u_rd_enc (
    .data  (rd_data),
    .check (rd_recalc)
  );

  assign syn = rd_recalc ^ rd_check;

  ecc72_classify u_cls (
    .syndrome  (syn),
    .kind      (kind),
    .flip_mask (flip_mask),
    .position  (position)
  );

  // next state
  logic [DATA_W-1:0] data_d;
  logic              ce_d, ue_d;
  logic [IDX_W-1:0]  bit_d;

  always_comb begin
    data_d = rd_data ^ flip_mask;
    ce_d   = (kind == ERR_CE);
    ue_d   = (kind == ERR_UE);
    bit_d  = (kind == ERR_CE) ? position : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= rd_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_data     <= '0;
      out_syndrome <= '0;
      out_ce       <= 1'b0;
      out_ue       <= 1'b0;
      out_bit      <= '0;
    end else if (rd_valid) begin
      out_data     <= data_d;
      out_syndrome <= syn;
      out_ce       <= ce_d;
      out_ue       <= ue_d;
      out_bit      <= bit_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |=> out_valid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_valid |=> !out_valid);

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(out_ce && out_ue));

  // R4
  clean_word_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_syndrome == '0) |-> (!out_ce && !out_ue && out_data == $past(rd_data)));

  // R6
  chk_hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_ce && out_bit >= 7'd64) |-> ($countones(out_syndrome) == 1 && out_data == $past(rd_data)));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_valid |=> ($stable(out_data) && $stable(out_syndrome) && $stable(out_bit)));
endmodule

// File: tb/test_ecc72_checker.sv
`timescale 1ns/1ps
module test_ecc72_checker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] wr_data;
  logic [7:0]  wr_check;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [7:0]  rd_check;
  logic        out_valid;
  logic [63:0] out_data;
  logic [7:0]  out_syndrome;
  logic        out_ce, out_ue;
  logic [6:0]  out_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ecc72_checker i_ecc72_checker (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_check(wr_check),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_check(rd_check),
    .out_valid(out_valid), .out_data(out_data), .out_syndrome(out_syndrome),
    .out_ce(out_ce), .out_ue(out_ue), .out_bit(out_bit)
  );

  localparam logic [7:0] TBL [64] = '{
    8'hf4, 8'hf1, 8'hec, 8'hea, 8'he9, 8'he6, 8'he5, 8'he3,
    8'hdc, 8'hda, 8'hd9, 8'hd6, 8'hd5, 8'hd3, 8'hce, 8'hcb,
    8'hb5, 8'hb0, 8'had, 8'hab, 8'ha8, 8'ha7, 8'ha4, 8'ha2,
    8'h9d, 8'h9b, 8'h98, 8'h97, 8'h94, 8'h92, 8'h8f, 8'h8a,
    8'h75, 8'h70, 8'h6d, 8'h6b, 8'h68, 8'h67, 8'h64, 8'h62,
    8'h5e, 8'h5b, 8'h58, 8'h57, 8'h54, 8'h52, 8'h4f, 8'h4a,
    8'h34, 8'h31, 8'h2c, 8'h2a, 8'h29, 8'h26, 8'h25, 8'h23,
    8'h1c, 8'h1a, 8'h19, 8'h16, 8'h15, 8'h13, 8'h0e, 8'h0b};

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [7:0] c = '0;
    for (int i = 0; i < 64; i++) if (d[i]) c = c ^ TBL[i];
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] orig, input logic [71:0] flips);
    logic [71:0] cw;
    logic [7:0]  syn;
    int          kind, pos;
    logic [63:0] exp_data;
    cw = {enc(orig), orig} ^ flips;
    @(negedge clk);
    rd_data  = cw[63:0];
    rd_check = cw[71:64];
    rd_valid = 1'b1;
    wr_data  = {$urandom, $urandom};
    #1;
    check(wr_check == enc(wr_data), "R1 wr_check", 80'(wr_check), 80'(enc(wr_data)));
    @(negedge clk);
    rd_valid = 1'b0;
    syn = enc(cw[63:0]) ^ cw[71:64];
    kind = 2; pos = 0; exp_data = cw[63:0];
    if (syn == 8'h00) kind = 0;
    for (int i = 0; i < 64; i++)
      if (syn == TBL[i]) begin kind = 1; pos = i; exp_data = cw[63:0] ^ (64'd1 << i); end
    for (int k = 0; k < 8; k++)
      if (syn == (8'd1 << k)) begin kind = 1; pos = 64 + k; end
    check(out_valid == 1'b1, "R2 out_valid", 80'(out_valid), 80'(1));
    check(out_syndrome == syn, "R3 syndrome", 80'(out_syndrome), 80'(syn));
    if (kind == 0)
      check(!out_ce && !out_ue && out_data == exp_data, "R4 clean",
            80'({out_ce, out_ue, out_data}), 80'({2'b00, exp_data}));
    else if (kind == 1 && pos < 64)
      check(out_ce && !out_ue && out_bit == 7'(pos) && out_data == exp_data, "R5 data bit",
            80'({out_ce, out_ue, out_bit, out_data}), 80'({2'b10, 7'(pos), exp_data}));
    else if (kind == 1)
      check(out_ce && !out_ue && out_bit == 7'(pos) && out_data == exp_data, "R6 check bit",
            80'({out_ce, out_ue, out_bit, out_data}), 80'({2'b10, 7'(pos), exp_data}));
    else
      check(!out_ce && out_ue && out_bit == 7'd0 && out_data == exp_data, "R7 uncorrectable",
            80'({out_ce, out_ue, out_bit, out_data}), 80'({2'b01, 7'd0, exp_data}));
    if ($countones(flips) == 1)
      check(out_data == orig, "R5 restored", 80'(out_data), 80'(orig));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [4];
    logic [63:0] held;
    logic [7:0]  held_syn;
    pats[0] = 64'h0;
    pats[1] = '1;
    pats[2] = 64'haaaa_5555_f0f0_0f0f;
    pats[3] = 64'h0123_4567_89ab_cdef;
    rst_n = 1'b0; rd_valid = 1'b0; rd_data = '0; rd_check = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0 && out_data == 0 && out_syndrome == 0 && !out_ce && !out_ue && out_bit == 0,
          "R8 reset", 80'({out_valid, out_ce, out_ue, out_bit, out_syndrome, out_data}), 80'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int p = 0; p < 4; p++) begin
      send(pats[p], 72'd0);
      for (int b = 0; b < 72; b++) send(pats[p], 72'd1 << b);
    end
    for (int n = 0; n < 300; n++) begin
      int a, b;
      a = $urandom_range(0, 71);
      b = $urandom_range(0, 70);
      if (b >= a) b++;
      send({$urandom, $urandom}, (72'd1 << a) | (72'd1 << b));
    end
    // R7 syndrome 0x03 from check bits 0 and 1
    send(pats[3], 72'd3 << 64);
    check(out_syndrome == 8'h03 && out_ue, "R7 pattern 03", 80'({out_ue, out_syndrome}), 80'({1'b1, 8'h03}));

    // R8 hold while idle
    send(pats[2], 72'd1 << 10);
    held = out_data; held_syn = out_syndrome;
    rd_data = ~pats[2]; rd_check = 8'h55;
    repeat (2) @(negedge clk);
    check(out_valid == 0, "R2 idle valid", 80'(out_valid), 80'(0));
    check(out_data == held && out_syndrome == held_syn && out_ce, "R8 hold",
          80'({out_syndrome, out_data}), 80'({held_syn, held}));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule